// File: doc/BRIEF.md
# Single-Wire Debug Link Timeout Monitor

This block watches the level of a bidirectional single-wire debug line, clocked by the target clock. The host begins every transfer by pulling the line low. The monitor measures each low pulse after a two-flop synchronizer. A pulse that ends within the bit threshold counts as a data bit cell. A pulse that stays low past that threshold is a SYNC request. After a SYNC request the block waits for the host to release the line, with no time limit. It then answers by driving a low response pulse of fixed length, drives the line high for one cycle and releases it.

Two watchdogs guard the link. The idle watchdog starts at every falling edge. If the next falling edge does not arrive within the idle limit, a one-cycle soft reset clears the partly received command. The read watchdog starts when read data becomes ready. If the host has not collected the data within the read limit while handshaking is off, it also fires the soft reset and the data is dropped. The command decoder and the memory access logic sit beside this block. They consume the bit strobe and the soft reset, and they report command completion and data collection back to it.

Top module: `dbglink_tmon`

## Requirements
- R1: The raw line passes two synchronizer flops. A falling edge on the line that occurs while no response is being driven gives a one-cycle `bit_start` pulse two clock cycles after the line goes low.
- R2: A synchronized low pulse of 128 cycles or fewer is a data bit. When the line returns high, `bit_cnt` increases by one. `bit_cnt` saturates at its all-ones value.
- R3: In the 129th consecutive synchronized low cycle, the pulse is classified as SYNC. `sync_det` is high from the next cycle until the synchronized rising edge. A SYNC clears `bit_cnt` and stops the idle watchdog without a soft reset.
- R4: While the line is held low after SYNC detection, no time limit applies. No soft reset and no response occur, however long the low pulse lasts.
- R5: One cycle after the synchronized rising edge that ends a SYNC, `drv_en` rises. `drv_val` is 0 for 128 cycles and then 1 for one cycle, and after that `drv_en` falls. Line edges caused by the response produce no `bit_start`.
- R6: If no new falling edge follows a falling edge within 512 cycles, `soft_rst` pulses for exactly one cycle, 512 cycles after the `bit_start` pulse. A falling edge that arrives exactly 512 cycles later prevents the pulse.
- R7: `soft_rst` clears `bit_cnt` and `rd_pend` on the next clock edge.
- R8: `rd_ready` sets `rd_pend`, and `rd_taken` clears it. With `hs_en` low, `soft_rst` pulses 512 cycles after the cycle in which `rd_ready` was high, unless the data was collected before that.
- R9: With `hs_en` high, the read watchdog is paused. `rd_pend` stays set and no soft reset comes from pending read data.
- R10: `cmd_done` clears `bit_cnt` and stops the idle watchdog, so no soft reset follows the end of a complete command.
- R11: After reset, `bit_start`, `sync_det`, `drv_en`, `drv_val`, `soft_rst` and `rd_pend` are 0, and `bit_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Raw level of the debug line |
| hs_en | input | 1 | Handshake enabled; pauses the read watchdog |
| rd_ready | input | 1 | Pulse: read data is ready for the host |
| rd_taken | input | 1 | Pulse: host has collected the read data |
| cmd_done | input | 1 | Pulse: decoder finished the current command |
| bit_start | output | 1 | One-cycle strobe at each host falling edge |
| sync_det | output | 1 | SYNC detected, waiting for line release |
| drv_en | output | 1 | Block drives the line |
| drv_val | output | 1 | Level driven while `drv_en` is high |
| soft_rst | output | 1 | One-cycle soft reset pulse |
| bit_cnt | output | BCNT_W | Data bits received in the current command |
| rd_pend | output | 1 | Read data waiting for collection |

## Verification
Low pulses of 10, 128, 129 and 1500 cycles are driven. These separate a plain bit, the last length that still counts as a bit, the first SYNC length, and a SYNC that is held far past both watchdog limits. Falling-edge gaps of 512 cycles and of unbounded length show the inclusive idle boundary and the timeout. Read data is left pending with handshaking off and with it on, which shows that only the first case drops the data. A burst of seventy short bits drives the bit counter into saturation. The response waveform is measured cycle by cycle against the line model, in which the block's drive overrides the host.

// File: rtl/dbglink_pkg.sv
package dbglink_pkg;

   // Link classifier states
   typedef enum logic [1:0] {
      LK_IDLE  = 2'd0,   // line high, waiting for host falling edge
      LK_LOW   = 2'd1,   // measuring a low pulse
      LK_SYNCW = 2'd2,   // SYNC seen, waiting for release (no limit)
      LK_RESP  = 2'd3    // driving the response pulse
   } lk_state_e;

   // Bits needed to hold values 0..lim
   function automatic int unsigned cnt_width(input int unsigned lim);
      return (lim < 2) ? 1 : $clog2(lim + 1);
   endfunction

endpackage

// File: rtl/dbglink_sync.sv
module dbglink_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_raw,
   output logic lvl,
   output logic fall,
   output logic rise
);
   // pipe[STAGES-1] is the synchronized level, pipe[STAGES] its previous value
   logic [STAGES:0] pipe_q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbglink_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-1:0], line_raw};
   end

   assign lvl  = pipe_q[STAGES-1];
   assign fall = pipe_q[STAGES] & ~pipe_q[STAGES-1];
   assign rise = ~pipe_q[STAGES] & pipe_q[STAGES-1];

endmodule

// File: rtl/dbglink_classify.sv
module dbglink_classify
   import dbglink_pkg::*;
#(
   parameter int unsigned LOW_LIM         = 128,
   parameter int unsigned RESP_LEN        = 128,
   parameter bit          RESP_DRIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   input  logic fall,
   input  logic rise,
   output logic bit_start,
   output logic bit_done,
   output logic sync_enter,
   output logic sync_wait,
   output logic drv_en,
   output logic drv_val
);
   localparam int unsigned LW = cnt_width(LOW_LIM);
   localparam int unsigned RW = cnt_width(RESP_LEN);
   localparam logic [LW-1:0] LOW_MAX   = LW'(LOW_LIM);
   localparam logic [RW-1:0] RESP_LAST = RESP_DRIVE_HIGH ? RW'(RESP_LEN) : RW'(RESP_LEN - 1);

   generate
      if (LOW_LIM < 2) begin : g_bad_low
         $error("dbglink_classify: LOW_LIM must be at least 2");
      end
      if (RESP_LEN < 2) begin : g_bad_resp
         $error("dbglink_classify: RESP_LEN must be at least 2");
      end
   endgenerate

   lk_state_e       state_q, state_d;
   logic [LW-1:0]   low_q;    // low cycles already seen in this pulse
   logic [RW-1:0]   resp_q;   // response cycle index

   always_comb begin
      state_d    = state_q;
      bit_done   = 1'b0;
      sync_enter = 1'b0;
      unique case (state_q)
         LK_IDLE: begin
            if (fall) state_d = LK_LOW;
         end
         LK_LOW: begin
            if (lvl) begin
               state_d  = LK_IDLE;
               bit_done = 1'b1;
            end else if (low_q == LOW_MAX) begin
               state_d    = LK_SYNCW;
               sync_enter = 1'b1;
            end
         end
         LK_SYNCW: begin
            if (rise) state_d = LK_RESP;
         end
         LK_RESP: begin
            if (resp_q == RESP_LAST) state_d = LK_IDLE;
         end
         default: state_d = LK_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= LK_IDLE;
      else        state_q <= state_d;
   end

   // Saturating low-time counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_q <= '0;
      end else if (state_q == LK_IDLE && fall) begin
         low_q <= LW'(1);
      end else if (state_q == LK_LOW && !lvl && low_q != LOW_MAX) begin
         low_q <= low_q + 1'b1;
      end
   end

   // Response cycle counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_q <= '0;
      end else if (state_q == LK_SYNCW && rise) begin
         resp_q <= '0;
      end else if (state_q == LK_RESP && resp_q != RESP_LAST) begin
         resp_q <= resp_q + 1'b1;
      end
   end

   assign bit_start = fall && (state_q == LK_IDLE);
   assign sync_wait = (state_q == LK_SYNCW);
   assign drv_en    = (state_q == LK_RESP);

   generate
      if (RESP_DRIVE_HIGH) begin : g_speedup
         assign drv_val = drv_en && (resp_q == RESP_LAST);
      end else begin : g_release_only
         assign drv_val = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/dbglink_wdog.sv
module dbglink_wdog
   import dbglink_pkg::*;
#(
   parameter int unsigned LIM = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,      // (re)start counting at 1
   input  logic cancel,   // stop without expiry
   input  logic clr,      // stop after soft reset
   input  logic hold,     // pause counting and expiry
   output logic armed,
   output logic expire
);
   localparam int unsigned CW = cnt_width(LIM);
   localparam logic [CW-1:0] CMAX = CW'(LIM);

   generate
      if (LIM < 2) begin : g_bad_lim
         $error("dbglink_wdog: LIM must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt_q <= '0;
      end else if (arm) begin
         armed <= 1'b1;
         cnt_q <= CW'(1);
      end else if (cancel || clr) begin
         armed <= 1'b0;
      end else if (armed && !hold && cnt_q != CMAX) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign expire = armed && !hold && !arm && !cancel && (cnt_q == CMAX);

endmodule

// File: rtl/dbglink_tmon.sv
module dbglink_tmon #(
   parameter int unsigned SYNC_STAGES     = 2,
   parameter int unsigned LOW_LIM         = 128,
   parameter int unsigned RESP_LEN        = 128,
   parameter bit          RESP_DRIVE_HIGH = 1'b1,
   parameter int unsigned IDLE_LIM        = 512,
   parameter int unsigned RD_LIM          = 512,
   parameter int unsigned BCNT_W          = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_in,
   input  logic              hs_en,
   input  logic              rd_ready,
   input  logic              rd_taken,
   input  logic              cmd_done,
   output logic              bit_start,
   output logic              sync_det,
   output logic              drv_en,
   output logic              drv_val,
   output logic              soft_rst,
   output logic [BCNT_W-1:0] bit_cnt,
   output logic              rd_pend
);
   generate
      if (BCNT_W < 1) begin : g_bad_bcnt
         $error("dbglink_tmon: BCNT_W must be at least 1");
      end
   endgenerate

   logic lvl, fall, rise;
   logic bit_done, sync_enter;
   logic idle_armed, idle_exp, rd_exp;

   dbglink_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_raw (line_in),
      .lvl      (lvl),
      .fall     (fall),
      .rise     (rise)
   );

   dbglink_classify #(
      .LOW_LIM         (LOW_LIM),
      .RESP_LEN        (RESP_LEN),
      .RESP_DRIVE_HIGH (RESP_DRIVE_HIGH)
   ) u_cls (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl        (lvl),
      .fall       (fall),
      .rise       (rise),
      .bit_start  (bit_start),
      .bit_done   (bit_done),
      .sync_enter (sync_enter),
      .sync_wait  (sync_det),
      .drv_en     (drv_en),
      .drv_val    (drv_val)
   );

   dbglink_wdog #(.LIM(IDLE_LIM)) u_idle (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (bit_start),
      .cancel (sync_enter | cmd_done),
      .clr    (soft_rst),
      .hold   (1'b0),
      .armed  (idle_armed),
      .expire (idle_exp)
   );

   dbglink_wdog #(.LIM(RD_LIM)) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (rd_ready),
      .cancel (rd_taken),
      .clr    (soft_rst),
      .hold   (hs_en),
      .armed  (rd_pend),
      .expire (rd_exp)
   );

   assign soft_rst = idle_exp | rd_exp;

   // Saturating count of received bits; any abort wins over a new bit
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt <= '0;
      end else if (soft_rst || cmd_done || sync_enter) begin
         bit_cnt <= '0;
      end else if (bit_done && bit_cnt != '1) begin
         bit_cnt <= bit_cnt + 1'b1;
      end
   end

   logic unused_armed;
   assign unused_armed = idle_armed;

endmodule

// File: rtl/dbglink_tmon_chk.sv
module dbglink_tmon_chk #(
   parameter int unsigned BCNT_W = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_ready,
   input logic              cmd_done,
   input logic              bit_start,
   input logic              sync_det,
   input logic              drv_en,
   input logic              drv_val,
   input logic              soft_rst,
   input logic [BCNT_W-1:0] bit_cnt,
   input logic              rd_pend
);
   // R6
   srst_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> !soft_rst);

   // R7
   srst_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (bit_cnt == '0));

   // R7
   srst_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst && !rd_ready) |=> !rd_pend);

   // R5
   resp_low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drv_en) |-> !drv_val);

   // R5
   resp_high_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drv_en && drv_val) |=> !drv_en);

   // R5
   resp_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_en |-> !bit_start);

   // R3
   sync_before_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sync_det |-> !drv_en);

   // R10
   cmd_done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done |=> (bit_cnt == '0));

   // R2
   bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_cnt != $past(bit_cnt)) |-> ((bit_cnt == $past(bit_cnt) + 1'b1) || (bit_cnt == '0)));

endmodule

bind dbglink_tmon dbglink_tmon_chk #(.BCNT_W(BCNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_ready  (rd_ready),
   .cmd_done  (cmd_done),
   .bit_start (bit_start),
   .sync_det  (sync_det),
   .drv_en    (drv_en),
   .drv_val   (drv_val),
   .soft_rst  (soft_rst),
   .bit_cnt   (bit_cnt),
   .rd_pend   (rd_pend)
);

// File: tb/dbglink_tmon_tb.sv
module dbglink_tmon_tb;
   localparam int CLK_PERIOD = 10;
   localparam int LOW_LIM    = 128;
   localparam int IDLE_LIM   = 512;
   localparam int RD_LIM     = 512;
   localparam int BCNT_W     = 6;

   localparam int EV_BIT  = 0;
   localparam int EV_SYNC = 1;
   localparam int EV_DRV  = 2;
   localparam int EV_SRST = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_lvl = 1'b1;
   logic hs_en = 1'b0, rd_ready = 1'b0, rd_taken = 1'b0, cmd_done = 1'b0;
   logic bit_start, sync_det, drv_en, drv_val, soft_rst, rd_pend;
   logic [BCNT_W-1:0] bit_cnt;
   logic line_w;

   int cyc = 0;
   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      int    kind;
      int    at;
      string req;
   } ev_t;
   ev_t expq[$];

   int resp_lo = 0, resp_hi = 0;

   // Line model: block drive overrides the host
   assign line_w = drv_en ? drv_val : host_lvl;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   dbglink_tmon #(.BCNT_W(BCNT_W)) u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_in   (line_w),
      .hs_en     (hs_en),
      .rd_ready  (rd_ready),
      .rd_taken  (rd_taken),
      .cmd_done  (cmd_done),
      .bit_start (bit_start),
      .sync_det  (sync_det),
      .drv_en    (drv_en),
      .drv_val   (drv_val),
      .soft_rst  (soft_rst),
      .bit_cnt   (bit_cnt),
      .rd_pend   (rd_pend)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
      end
   endtask

   task automatic push(input int kind, input int at, input string req);
      ev_t e;
      e.kind = kind; e.at = at; e.req = req;
      expq.push_back(e);
   endtask

   task automatic observe(input int kind);
      ev_t e;
      n_checks++;
      if (expq.size() == 0) begin
         n_fail++;
         $display("FAIL R1/R4/R6 unexpected event kind %0d at cycle %0d: actual event, expected none", kind, cyc);
      end else begin
         e = expq.pop_front();
         if (e.kind != kind || e.at != cyc) begin
            n_fail++;
            $display("FAIL %s event: actual kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                     e.req, kind, cyc, e.kind, e.at);
         end
      end
   endtask

   // Monitor: sample 2 time units after the falling edge
   logic p_sync = 1'b0, p_drv = 1'b0;
   always begin
      @(negedge clk);
      #2;
      if (rst_n) begin
         if (bit_start)           observe(EV_BIT);
         if (sync_det && !p_sync) observe(EV_SYNC);
         if (drv_en && !p_drv) begin
            observe(EV_DRV);
            resp_lo = 0;
            resp_hi = 0;
         end
         if (drv_en) begin
            if (drv_val) resp_hi++;
            else         resp_lo++;
         end
         if (soft_rst)            observe(EV_SRST);
      end
      p_sync = sync_det;
      p_drv  = drv_en;
   end

   task automatic wait_until(input int t);
      while (cyc < t) @(negedge clk);
   endtask

   // Called just after a falling clock edge
   task automatic host_low(input int len, input int gap);
      int a;
      a = cyc;
      host_lvl = 1'b0;
      push(EV_BIT, a + 2, "R1");
      if (len > LOW_LIM) begin
         push(EV_SYNC, a + LOW_LIM + 3, "R3");
         push(EV_DRV, a + len + 3, "R5");
      end
      repeat (len) @(negedge clk);
      if (len >= LOW_LIM + 3) begin
         check("R4 sync_det held", sync_det, 1);
         check("R4 no drive yet", drv_en, 0);
      end
      host_lvl = 1'b1;
      repeat (gap) @(negedge clk);
   endtask

   task automatic pulse_cmd_done();
      cmd_done = 1'b1;
      @(negedge clk);
      cmd_done = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired at cycle %0d: actual hang, expected completion", cyc);
         $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      int a, r;
      repeat (3) @(negedge clk);
      // R11 reset state
      check("R11 bit_start", bit_start, 0);
      check("R11 sync_det", sync_det, 0);
      check("R11 drv_en", drv_en, 0);
      check("R11 drv_val", drv_val, 0);
      check("R11 soft_rst", soft_rst, 0);
      check("R11 bit_cnt", int'(bit_cnt), 0);
      check("R11 rd_pend", rd_pend, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2: short bit and longest bit
      host_low(10, 6);
      check("R2 bit_cnt after 10-cycle bit", int'(bit_cnt), 1);
      host_low(LOW_LIM, 6);
      check("R2 bit_cnt after 128-cycle bit", int'(bit_cnt), 2);
      // R10: command end clears count, no later soft reset
      pulse_cmd_done();
      check("R10 bit_cnt cleared", int'(bit_cnt), 0);
      repeat (700) @(negedge clk);

      // R6 / R7: idle timeout
      a = cyc;
      host_low(10, 20);
      push(EV_SRST, a + 2 + IDLE_LIM, "R6");
      check("R2 bit counted before timeout", int'(bit_cnt), 1);
      wait_until(a + IDLE_LIM + 10);
      check("R7 bit_cnt cleared by soft reset", int'(bit_cnt), 0);

      // R6 boundary: next falling edge exactly at the limit
      a = cyc;
      host_low(10, 20);
      wait_until(a + IDLE_LIM);
      host_low(10, 20);
      check("R6 no timeout at exact limit", int'(bit_cnt), 2);
      pulse_cmd_done();
      check("R10 cleared after command", int'(bit_cnt), 0);

      // R3 / R5: shortest SYNC, clears partial command
      host_low(10, 10);
      check("R2 partial command bit", int'(bit_cnt), 1);
      host_low(LOW_LIM + 1, 200);
      check("R3 bit_cnt cleared by sync", int'(bit_cnt), 0);
      check("R5 response low cycles", resp_lo, 128);
      check("R5 response high cycles", resp_hi, 1);
      check("R5 released", drv_en, 0);

      // R4: very long SYNC, beyond both watchdog limits
      host_low(1500, 200);
      check("R5 long sync response low cycles", resp_lo, 128);
      check("R4 bit_cnt after long sync", int'(bit_cnt), 0);

      // R8: read data dropped with handshake off
      r = cyc;
      rd_ready = 1'b1;
      push(EV_SRST, r + RD_LIM, "R8");
      @(negedge clk);
      rd_ready = 1'b0;
      wait_until(r + 100);
      check("R8 rd_pend set", rd_pend, 1);
      wait_until(r + RD_LIM + 10);
      check("R8 rd_pend dropped", rd_pend, 0);

      // R9: handshake on, no read timeout
      hs_en = 1'b1;
      @(negedge clk);
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      repeat (800) @(negedge clk);
      check("R9 rd_pend kept", rd_pend, 1);
      rd_taken = 1'b1;
      @(negedge clk);
      rd_taken = 1'b0;
      @(negedge clk);
      check("R9 rd_pend cleared by collection", rd_pend, 0);
      hs_en = 1'b0;
      repeat (600) @(negedge clk);

      // R2: saturation of the bit counter
      for (int i = 0; i < 70; i++) host_low(3, 3);
      check("R2 bit_cnt saturates", int'(bit_cnt), (1 << BCNT_W) - 1);
      pulse_cmd_done();

      repeat (20) @(negedge clk);
      check("R1 all expected events seen", expq.size(), 0);

      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule